// File: doc/BRIEF.md
# Two-Sided Message Mailbox

This block joins two agents, a guest side and a host side, through a pair of one-way message channels. Each side has its own small word-addressed register port. On that port it can fill an outgoing buffer of four 32-bit words, read the incoming buffer that the peer filled, and drive a control register for each direction. A sender loads its words and then sets its posted flag. The receiver sees that flag, reads the words and writes an acknowledge. The sender then sees the acknowledge in its own transmit control register.

The acknowledge is chained and cleared by hardware. When the sender withdraws its posted flag, the receiver's acknowledge drops on the next clock edge. The acknowledge that the sender sees is that same bit, so it drops too, and a stale acknowledge can never carry over to the next message. Each side has two interrupt enables, one for "message arrived" and one for "acknowledge arrived". Each enabled event produces a single-cycle registered pulse.

Register map, the same on each side (word address): 0..3 outgoing words, 4..7 incoming words (read only), 8 transmit control, 9 receive control, 10 interrupt enable. Any other address reads zero.

Top module: `mbx_dual`

## Requirements
- R1: After reset, every register on both sides reads zero (words, control and enables), and all four interrupt outputs are low.
- R2: A word written at address k (0..3) reads back at address k on the same side, and reads at address 4+k on the peer side in the cycle after the write edge.
- R3: A write to an outgoing word while that side's posted flag (transmit control bit 0) is 1 is ignored, on both the local and the peer view.
- R4: Writing transmit control sets bit 0 (posted) to wdata bit 0. The peer's receive control bit 0 (message valid) equals that flag.
- R5: Writing receive control with wdata bit 1 set, while receive bit 0 is 1, sets receive bit 1 (acknowledge). The peer's transmit control bit 1 then reads 1. The same write while no message is posted has no effect.
- R6: When a sender clears its posted flag, the receiver's receive control reads 2 for one cycle and then 0, and the sender's transmit control reads 0.
- R7: Transmit control bit 1 is read only: a write of 1 to it does not change what it reads.
- R8: When interrupt enable bit 0 is 1, a message-arrived output pulses high for exactly one cycle, the cycle after the edge at which receive bit 0 rises. When the enable is 0 it stays low.
- R9: When interrupt enable bit 1 is 1, an acknowledge-arrived output pulses high for exactly one cycle, the cycle after the edge at which transmit bit 1 rises. When the enable is 0 it stays low.
- R10: Incoming words stay readable after the handshake completes and the posted flag is withdrawn.
- R11: The interrupt enable register bits 1:0 are writable and read back as written, independently on each side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| g_we | input | 1 | Guest write strobe |
| g_addr | input | 4 | Guest word address |
| g_wdata | input | 32 | Guest write data |
| g_rdata | output | 32 | Guest read data (combinational on g_addr) |
| g_irq_msg | output | 1 | Guest message-arrived pulse |
| g_irq_ack | output | 1 | Guest acknowledge-arrived pulse |
| h_we | input | 1 | Host write strobe |
| h_addr | input | 4 | Host word address |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data (combinational on h_addr) |
| h_irq_msg | output | 1 | Host message-arrived pulse |
| h_irq_ack | output | 1 | Host acknowledge-arrived pulse |

## Verification
The hardest state to reach from the ports is the one-cycle window after a sender withdraws its flag. In that window the receiver still holds its acknowledge while the message valid bit is already low. The bench reaches it by completing a full post-and-acknowledge exchange and then clearing the posted flag. It reads the receiver's control register in the very next cycle and again one cycle later. It runs this sequence in both directions and under all four enable combinations, so each interrupt pulse is checked both when it must fire and when it must stay silent.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  typedef enum logic [2:0] {
    RK_TXW  = 3'd0,
    RK_RXW  = 3'd1,
    RK_TXC  = 3'd2,
    RK_RXC  = 3'd3,
    RK_IEN  = 3'd4,
    RK_NONE = 3'd5
  } reg_kind_e;

  // Map a word address onto a register class; layout scales with word count.
  function automatic reg_kind_e decode_reg(logic [31:0] a, logic [31:0] nw);
    if (a < nw)                 return RK_TXW;
    else if (a < 2 * nw)        return RK_RXW;
    else if (a == 2 * nw)       return RK_TXC;
    else if (a == 2 * nw + 1)   return RK_RXC;
    else if (a == 2 * nw + 2)   return RK_IEN;
    else                        return RK_NONE;
  endfunction

endpackage

// File: rtl/mbx_rst_sync.sv
module mbx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic s1_q;
  logic s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_n_sync = s2_q;

endmodule

// File: rtl/mbx_irq_edge.sv
module mbx_irq_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic flag,
  input  logic en,
  output logic pulse
);

  logic flag_q;
  logic pulse_q;
  logic pulse_d;

  always_comb begin
    pulse_d = en & flag & ~flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      flag_q  <= flag;
      pulse_q <= pulse_d;
    end
  end

  assign pulse = pulse_q;

endmodule

// File: rtl/mbx_side.sv
module mbx_side
  import mbx_pkg::*;
#(
  parameter int DW = 32,
  parameter int NW = 4,
  parameter int AW = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [AW-1:0]          addr,
  input  logic [DW-1:0]          wdata,
  output logic [DW-1:0]          rdata,
  input  logic                   peer_valid,
  input  logic [NW-1:0][DW-1:0]  peer_words,
  input  logic                   peer_rx_ack,
  output logic                   tx_valid,
  output logic [NW-1:0][DW-1:0]  tx_words,
  output logic                   rx_ack,
  output logic [1:0]             ien,
  output logic                   irq_msg,
  output logic                   irq_ack
);

  localparam int WIW = (NW > 1) ? $clog2(NW) : 1;

  reg_kind_e            kind;
  logic [WIW-1:0]       widx;

  logic [NW-1:0][DW-1:0] words_q;
  logic [NW-1:0]         words_en;
  logic                  valid_q, valid_d, valid_en;
  logic                  ack_q, ack_d, ack_en;
  logic [1:0]            ien_q, ien_d;
  logic                  ien_en;

  always_comb begin
    kind = decode_reg(32'(addr), 32'(NW));
    widx = WIW'(addr);
  end

  // Next-state and clock enables
  always_comb begin
    for (int w = 0; w < NW; w++) begin
      words_en[w] = we && (kind == RK_TXW) && !valid_q && (widx == WIW'(w));
    end
    valid_en = we && (kind == RK_TXC);
    valid_d  = wdata[0];
    // Acknowledge lives only while the peer keeps its message posted.
    ack_d    = peer_valid && (ack_q || (we && (kind == RK_RXC) && wdata[1]));
    ack_en   = (ack_d != ack_q);
    ien_en   = we && (kind == RK_IEN);
    ien_d    = wdata[1:0];
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      words_q <= '0;
      valid_q <= 1'b0;
      ack_q   <= 1'b0;
      ien_q   <= 2'b00;
    end else begin
      for (int w = 0; w < NW; w++) begin
        if (words_en[w]) words_q[w] <= wdata;
      end
      if (valid_en) valid_q <= valid_d;
      if (ack_en)   ack_q   <= ack_d;
      if (ien_en)   ien_q   <= ien_d;
    end
  end

  // Read mux
  always_comb begin
    case (kind)
      RK_TXW:  rdata = words_q[widx];
      RK_RXW:  rdata = peer_words[widx];
      RK_TXC:  rdata = DW'({peer_rx_ack, valid_q});
      RK_RXC:  rdata = DW'({ack_q, peer_valid});
      RK_IEN:  rdata = DW'(ien_q);
      default: rdata = '0;
    endcase
  end

  mbx_irq_edge u_irq_msg (
    .clk   (clk),
    .rst_n (rst_n),
    .flag  (peer_valid),
    .en    (ien_q[0]),
    .pulse (irq_msg)
  );

  mbx_irq_edge u_irq_ack (
    .clk   (clk),
    .rst_n (rst_n),
    .flag  (peer_rx_ack),
    .en    (ien_q[1]),
    .pulse (irq_ack)
  );

  assign tx_valid = valid_q;
  assign tx_words = words_q;
  assign rx_ack   = ack_q;
  assign ien      = ien_q;

endmodule

// File: rtl/mbx_dual.sv
module mbx_dual #(
  parameter int DW = 32,
  parameter int NW = 4,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          g_we,
  input  logic [AW-1:0] g_addr,
  input  logic [DW-1:0] g_wdata,
  output logic [DW-1:0] g_rdata,
  output logic          g_irq_msg,
  output logic          g_irq_ack,
  input  logic          h_we,
  input  logic [AW-1:0] h_addr,
  input  logic [DW-1:0] h_wdata,
  output logic [DW-1:0] h_rdata,
  output logic          h_irq_msg,
  output logic          h_irq_ack
);

  localparam int NS = 2;

  logic                           rst_n_sync;
  logic [NS-1:0]                  we_s;
  logic [NS-1:0][AW-1:0]          addr_s;
  logic [NS-1:0][DW-1:0]          wdata_s;
  logic [NS-1:0][DW-1:0]          rdata_s;
  logic [NS-1:0]                  tx_valid;
  logic [NS-1:0]                  rx_ack;
  logic [NS-1:0]                  irq_msg;
  logic [NS-1:0]                  irq_ack;
  logic [NS-1:0]                  ien_msg;
  logic [NS-1:0]                  ien_ack;
  logic [NS-1:0][1:0]             ien;
  logic [NS-1:0][NW-1:0][DW-1:0]  tx_words;

  mbx_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  assign we_s    = {h_we, g_we};
  assign addr_s  = {h_addr, g_addr};
  assign wdata_s = {h_wdata, g_wdata};

  assign g_rdata   = rdata_s[0];
  assign h_rdata   = rdata_s[1];
  assign g_irq_msg = irq_msg[0];
  assign h_irq_msg = irq_msg[1];
  assign g_irq_ack = irq_ack[0];
  assign h_irq_ack = irq_ack[1];

  for (genvar s = 0; s < NS; s++) begin : g_side
    mbx_side #(.DW(DW), .NW(NW), .AW(AW)) u_side (
      .clk         (clk),
      .rst_n       (rst_n_sync),
      .we          (we_s[s]),
      .addr        (addr_s[s]),
      .wdata       (wdata_s[s]),
      .rdata       (rdata_s[s]),
      .peer_valid  (tx_valid[NS-1-s]),
      .peer_words  (tx_words[NS-1-s]),
      .peer_rx_ack (rx_ack[NS-1-s]),
      .tx_valid    (tx_valid[s]),
      .tx_words    (tx_words[s]),
      .rx_ack      (rx_ack[s]),
      .ien         (ien[s]),
      .irq_msg     (irq_msg[s]),
      .irq_ack     (irq_ack[s])
    );
    assign ien_msg[s] = ien[s][0];
    assign ien_ack[s] = ien[s][1];
  end

endmodule

// File: rtl/mbx_dual_chk.sv
module mbx_dual_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] tx_valid,
  input logic [1:0] rx_ack,
  input logic [1:0] irq_msg,
  input logic [1:0] irq_ack,
  input logic [1:0] ien_msg,
  input logic [1:0] ien_ack
);

  for (genvar s = 0; s < 2; s++) begin : g_chk
    localparam int P = 1 - s;

    // R6: a withdrawn message drops the receiver's acknowledge on the next edge
    a_r6_ack_follows_post: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_valid[P] |=> !rx_ack[s]);

    // R5: an acknowledge can only appear while the peer had a message posted
    a_r5_ack_needs_post: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_ack[s]) |-> $past(tx_valid[P]));

    // R8: message pulse is caused by an enabled rising valid
    a_r8_msg_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
      irq_msg[s] |-> ($past(ien_msg[s]) && $past(tx_valid[P]) && !$past(tx_valid[P], 2)));

    // R8: message pulse lasts a single cycle
    a_r8_msg_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
      irq_msg[s] |=> !irq_msg[s]);

    // R9: acknowledge pulse is caused by an enabled rising acknowledge
    a_r9_ack_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack[s] |-> ($past(ien_ack[s]) && $past(rx_ack[P]) && !$past(rx_ack[P], 2)));

    // R9: acknowledge pulse lasts a single cycle
    a_r9_ack_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack[s] |=> !irq_ack[s]);
  end

endmodule

bind mbx_dual mbx_dual_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n_sync),
  .tx_valid (tx_valid),
  .rx_ack   (rx_ack),
  .irq_msg  (irq_msg),
  .irq_ack  (irq_ack),
  .ien_msg  (ien_msg),
  .ien_ack  (ien_ack)
);

// File: tb/tb_mbx_dual.sv
module tb_mbx_dual;

  localparam logic [3:0] A_TXC = 4'd8;
  localparam logic [3:0] A_RXC = 4'd9;
  localparam logic [3:0] A_IEN = 4'd10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        g_we, h_we;
  logic [3:0]  g_addr, h_addr;
  logic [31:0] g_wdata, h_wdata, g_rdata, h_rdata;
  logic        g_irq_msg, g_irq_ack, h_irq_msg, h_irq_ack;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  mbx_dual dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .g_we      (g_we),
    .g_addr    (g_addr),
    .g_wdata   (g_wdata),
    .g_rdata   (g_rdata),
    .g_irq_msg (g_irq_msg),
    .g_irq_ack (g_irq_ack),
    .h_we      (h_we),
    .h_addr    (h_addr),
    .h_wdata   (h_wdata),
    .h_rdata   (h_rdata),
    .h_irq_msg (h_irq_msg),
    .h_irq_ack (h_irq_ack)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(input int s, input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    if (s == 0) begin g_we = 1'b1; g_addr = a; g_wdata = d; end
    else        begin h_we = 1'b1; h_addr = a; h_wdata = d; end
    @(negedge clk);
    g_we = 1'b0;
    h_we = 1'b0;
  endtask

  task automatic rdchk(input int s, input logic [3:0] a, input logic [31:0] exp, input string tag);
    if (s == 0) g_addr = a; else h_addr = a;
    #1;
    chk(tag, (s == 0) ? g_rdata : h_rdata, exp);
  endtask

  function automatic logic irq_m(input int s);
    return (s == 0) ? g_irq_msg : h_irq_msg;
  endfunction

  function automatic logic irq_a(input int s);
    return (s == 0) ? g_irq_ack : h_irq_ack;
  endfunction

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    g_we = 1'b0; h_we = 1'b0;
    g_addr = '0; h_addr = '0;
    g_wdata = '0; h_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state on every address of both sides
    for (int s = 0; s < 2; s++) begin
      for (int a = 0; a < 11; a++) rdchk(s, 4'(a), 32'h0, "R1 reset register");
      chk("R1 irq_msg reset", 32'(irq_m(s)), 32'h0);
      chk("R1 irq_ack reset", 32'(irq_a(s)), 32'h0);
    end

    for (int dir = 0; dir < 2; dir++) begin
      for (int en = 0; en < 4; en++) begin
        int snd = dir;
        int rcv = 1 - dir;
        logic [31:0] base = 32'hA500_0000 ^ (32'(dir) << 20) ^ (32'(en) << 16);

        // R5: acknowledge with nothing posted has no effect
        wr(rcv, A_RXC, 32'h2);
        rdchk(rcv, A_RXC, 32'h0, "R5 ack without post (rx)");
        rdchk(snd, A_TXC, 32'h0, "R5 ack without post (tx)");

        // R11: enables
        wr(snd, A_IEN, 32'(en));
        wr(rcv, A_IEN, 32'(en));
        rdchk(snd, A_IEN, 32'(en), "R11 enable readback sender");
        rdchk(rcv, A_IEN, 32'(en), "R11 enable readback receiver");

        // R2: load words
        for (int k = 0; k < 4; k++) wr(snd, 4'(k), base + 32'(k) * 32'h0101_0101);
        for (int k = 0; k < 4; k++) begin
          rdchk(snd, 4'(k),     base + 32'(k) * 32'h0101_0101, "R2 local readback");
          rdchk(rcv, 4'(4 + k), base + 32'(k) * 32'h0101_0101, "R2 peer view");
        end

        // R4 / R8: post
        wr(snd, A_TXC, 32'h1);
        chk("R8 msg irq not before register", 32'(irq_m(rcv)), 32'h0);
        rdchk(rcv, A_RXC, 32'h1, "R4 rx valid mirrors post");
        rdchk(snd, A_TXC, 32'h1, "R4 tx valid readback");
        @(negedge clk);
        chk("R8 msg irq pulse", 32'(irq_m(rcv)), 32'(en & 1));
        @(negedge clk);
        chk("R8 msg irq one cycle", 32'(irq_m(rcv)), 32'h0);

        // R3: locked words
        wr(snd, 4'd0, 32'hDEAD_BEEF);
        rdchk(snd, 4'd0, base, "R3 locked word local");
        rdchk(rcv, 4'd4, base, "R3 locked word peer");

        // R7: tx ack bit is read only
        wr(snd, A_TXC, 32'h3);
        rdchk(snd, A_TXC, 32'h1, "R7 tx ack read only");

        // R5 / R9: acknowledge
        wr(rcv, A_RXC, 32'h2);
        rdchk(rcv, A_RXC, 32'h3, "R5 rx ack set");
        rdchk(snd, A_TXC, 32'h3, "R5 sender sees ack");
        chk("R9 ack irq not before register", 32'(irq_a(snd)), 32'h0);
        @(negedge clk);
        chk("R9 ack irq pulse", 32'(irq_a(snd)), 32'((en >> 1) & 1));
        @(negedge clk);
        chk("R9 ack irq one cycle", 32'(irq_a(snd)), 32'h0);

        // R6: chained clear
        wr(snd, A_TXC, 32'h0);
        rdchk(rcv, A_RXC, 32'h2, "R6 ack held one cycle");
        @(negedge clk);
        rdchk(rcv, A_RXC, 32'h0, "R6 rx ack cleared");
        rdchk(snd, A_TXC, 32'h0, "R6 sender ack cleared");

        // R10: words persist
        rdchk(rcv, 4'd6, base + 32'h0202_0202, "R10 word 2 persists");
      end
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule